// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block links two parallel buses, called A and B. Each direction has its own storage register, and that register has its own capture clock. On every rising edge of its clock, a register loads the word on its source bus. The select and enable levels have no effect on this capture.

A per-direction select picks what goes to the far bus. It is either the live word from the source bus or the word last captured. A per-direction enable turns that direction's drive on or off. Each port is presented as an input vector, an output vector and an output-enable flag. The surrounding logic, or a bench wrapper, resolves these into a real shared bus.

The select multiplexer is built in a hazard-free form. A bit that has the same value in the live and the stored source keeps its value while the select changes. When both directions pass live data and both are enabled, each output feeds back onto the other bus. Once all outside drivers release, both buses keep their last value.

Top module: `xcvr_dual_reg`

## Requirements
- R1: While `rst_n` is low, both storage registers clear asynchronously to zero. After reset, with both selects high, `b_out` and `a_out` are 0x00.
- R2: On each rising edge of `clk_ab`, the A-side register loads `a_in`. The levels of `sel_ab`, `sel_ba`, `en_ab` and `en_ba_n` do not affect this capture.
- R3: On each rising edge of `clk_ba`, the B-side register loads `b_in`. The select and enable levels do not affect this capture.
- R4: When `sel_ab` is 0, `b_out` equals the live `a_in`. When `sel_ab` is 1, `b_out` equals the A-side register.
- R5: When `sel_ba` is 0, `a_out` equals the live `b_in`. When `sel_ba` is 1, `a_out` equals the B-side register.
- R6: `b_oe` is 1 exactly when `en_ab` is 1 (active high). `a_oe` is 1 exactly when `en_ba_n` is 0 (active low).
- R7: While a select changes, every output bit whose live and stored sources are equal holds its value, with no transient change.
- R8: A capture edge on one clock leaves the other direction's register unchanged.
- R9: With both selects at 0 and both directions enabled, `b_out` follows `a_in` and `a_out` follows `b_in`. After the outside drivers release, both buses therefore hold their last word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| sel_ab | input | 1 | A-to-B source select: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source select: 0 live, 1 stored |
| en_ab | input | 1 | A-to-B drive enable, active high |
| en_ba_n | input | 1 | B-to-A drive enable, active low |
| a_in | input | W | Word seen on bus A |
| b_in | input | W | Word seen on bus B |
| a_out | output | W | Word offered for bus A |
| a_oe | output | 1 | Drive bus A with `a_out` |
| b_out | output | W | Word offered for bus B |
| b_oe | output | 1 | Drive bus B with `b_out` |

## Verification
A stored word that is wrong appears only when that direction's select is high. The first stored-mode read after the bad capture exposes it, on the same cycle, because the path is purely combinational. A register struck by the wrong clock shows the opposite word on its output during the next stored read. A multiplexer without the hazard-free consensus term can show a spurious change on matching bits during a select edge. An event monitor on the outputs catches that change at the moment it occurs. A broken enable decode, or a broken live path, shows up at once as a bus that floats or fails to hold in the mutual-enable case.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         cap_clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_hf_mux.sv
module xcvr_hf_mux #(
  parameter int unsigned W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] y
);
  // Sum-of-products with the consensus term: a bit equal in both sources
  // is held by live&held regardless of the select transition.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = (~sel & live[i]) | (sel & held[i]) | (live[i] & held[i]);
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned W      = 8,
  parameter bit          EN_LOW = 1'b0
) (
  input  logic         cap_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_in,
  input  logic         sel,
  input  logic         en,
  output logic [W-1:0] dst_out,
  output logic         dst_oe
);
  import xcvr_pkg::*;

  logic [W-1:0] held_q;
  src_sel_e     sel_e;

  assign sel_e = src_sel_e'(sel);

  xcvr_store #(.W(W)) u_store (
    .cap_clk (cap_clk),
    .rst_n   (rst_n),
    .d       (src_in),
    .q       (held_q)
  );

  xcvr_hf_mux #(.W(W)) u_mux (
    .sel  (sel_e == SRC_STORED),
    .live (src_in),
    .held (held_q),
    .y    (dst_out)
  );

  if (EN_LOW) begin : g_en_low
    assign dst_oe = ~en;
  end else begin : g_en_high
    assign dst_oe = en;
  end
endmodule

// File: rtl/xcvr_dual_reg.sv
module xcvr_dual_reg #(
  parameter int unsigned W = xcvr_pkg::XCVR_W
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  xcvr_lane #(.W(W), .EN_LOW(1'b0)) u_ab (
    .cap_clk (clk_ab),
    .rst_n   (rst_n),
    .src_in  (a_in),
    .sel     (sel_ab),
    .en      (en_ab),
    .dst_out (b_out),
    .dst_oe  (b_oe)
  );

  xcvr_lane #(.W(W), .EN_LOW(1'b1)) u_ba (
    .cap_clk (clk_ba),
    .rst_n   (rst_n),
    .src_in  (b_in),
    .sel     (sel_ba),
    .en      (en_ba_n),
    .dst_out (a_out),
    .dst_oe  (a_oe)
  );
endmodule

// File: rtl/xcvr_dual_reg_chk.sv
module xcvr_dual_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  logic [W-1:0] shadow_a;
  logic [W-1:0] shadow_b;

  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n) shadow_a <= '0;
    else        shadow_a <= a_in;
  end

  always_ff @(posedge clk_ba or negedge rst_n) begin
    if (!rst_n) shadow_b <= '0;
    else        shadow_b <= b_in;
  end

  a_r2_capture_ab: assert property (@(negedge clk_ab) disable iff (!rst_n)
    sel_ab |-> (b_out == shadow_a));
  a_r3_capture_ba: assert property (@(negedge clk_ba) disable iff (!rst_n)
    sel_ba |-> (a_out == shadow_b));
  a_r4_live_ab: assert property (@(negedge clk_ab) disable iff (!rst_n)
    !sel_ab |-> (b_out == a_in));
  a_r5_live_ba: assert property (@(negedge clk_ba) disable iff (!rst_n)
    !sel_ba |-> (a_out == b_in));
  a_r6_oe_ab: assert property (@(negedge clk_ab) disable iff (!rst_n)
    b_oe == en_ab);
  a_r6_oe_ba: assert property (@(negedge clk_ba) disable iff (!rst_n)
    a_oe == !en_ba_n);
  a_r7_no_glitch_ab: assert property (@(negedge clk_ab) disable iff (!rst_n)
    ((b_out ^ a_in) & ~(shadow_a ^ a_in)) == '0);
  a_r7_no_glitch_ba: assert property (@(negedge clk_ba) disable iff (!rst_n)
    ((a_out ^ b_in) & ~(shadow_b ^ b_in)) == '0);
  a_r8_ba_untouched: assert property (@(negedge clk_ab) disable iff (!rst_n)
    sel_ba |-> (a_out == shadow_b));
endmodule

bind xcvr_dual_reg xcvr_dual_reg_chk #(.W(W)) u_chk (.*);

// File: tb/xcvr_dual_reg_test.sv
`timescale 1ns/100ps
module xcvr_dual_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, clk_ab = 1'b0, clk_ba = 1'b0;
  logic sel_ab = 1'b0, sel_ba = 1'b0, en_ab = 1'b0, en_ba_n = 1'b1;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic ext_a_en = 1'b1, ext_b_en = 1'b1;
  logic [W-1:0] bus_a = '0, bus_b = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int total = 0, bad = 0;
  bit finished = 0;

  xcvr_dual_reg #(.W(W)) uut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_in(bus_a), .b_in(bus_b),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  // Bus resolution: external driver wins, else the block's drive, else float.
  task automatic settle();
    for (int k = 0; k < 4; k++) begin
      #1;
      bus_a = ext_a_en ? ext_a : (a_oe ? a_out : 'z);
      bus_b = ext_b_en ? ext_b : (b_oe ? b_out : 'z);
    end
    #1;
  endtask

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic pulse_ab();
    clk_ab = 1'b1; #1; clk_ab = 1'b0; #1;
  endtask

  task automatic pulse_ba();
    clk_ba = 1'b1; #1; clk_ba = 1'b0; #1;
  endtask

  // Glitch monitor on bits equal in both sources.
  bit watch = 0;
  bit glitch = 0;
  logic [W-1:0] mask_w = '0, ref_w = '0;
  bit watch_b = 1;
  always @(a_out or b_out) begin
    if (watch) begin
      if (watch_b && (((b_out ^ ref_w) & mask_w) != '0)) glitch = 1;
      if (!watch_b && (((a_out ^ ref_w) & mask_w) != '0)) glitch = 1;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    sel_ab = 1'b1; sel_ba = 1'b1;
    settle();
    check("R1 b_out after reset", b_out, 8'h00);
    check("R1 a_out after reset", a_out, 8'h00);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_store_disabled();
    @(negedge clk);
    en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    ext_a = 8'h3C; ext_b = 8'hA5; settle();
    pulse_ab(); pulse_ba();
    ext_a = 8'h00; ext_b = 8'h00; settle();
    sel_ab = 1'b1; sel_ba = 1'b1; en_ab = 1'b1; en_ba_n = 1'b0; settle();
    check("R2 stored A word while disabled", b_out, 8'h3C);
    check("R3 stored B word while disabled", a_out, 8'hA5);
    ext_a = 8'h11; settle(); pulse_ab(); settle();
    check("R2 new A capture", b_out, 8'h11);
    check("R8 B register after clk_ab", a_out, 8'hA5);
    ext_b = 8'h77; settle(); pulse_ba(); settle();
    check("R3 new B capture", a_out, 8'h77);
    check("R8 A register after clk_ba", b_out, 8'h11);
  endtask

  task automatic t_select();
    @(negedge clk);
    ext_a = 8'h96; ext_b = 8'h4B; sel_ab = 1'b0; sel_ba = 1'b0; settle();
    check("R4 live A to B", b_out, 8'h96);
    check("R5 live B to A", a_out, 8'h4B);
    sel_ab = 1'b1; sel_ba = 1'b1; settle();
    check("R4 stored A to B", b_out, 8'h11);
    check("R5 stored B to A", a_out, 8'h77);
  endtask

  task automatic t_oe();
    @(negedge clk);
    en_ab = 1'b0; en_ba_n = 1'b1; settle();
    check("R6 b_oe off", {7'd0, b_oe}, 8'h00);
    check("R6 a_oe off", {7'd0, a_oe}, 8'h00);
    en_ab = 1'b1; en_ba_n = 1'b0; settle();
    check("R6 b_oe on", {7'd0, b_oe}, 8'h01);
    check("R6 a_oe on", {7'd0, a_oe}, 8'h01);
    en_ab = 1'b0; settle();
    check("R6 independent a_oe", {7'd0, a_oe}, 8'h01);
    en_ab = 1'b1;
  endtask

  task automatic t_glitch();
    @(negedge clk);
    ext_a = 8'h1F; sel_ab = 1'b0; settle();
    ref_w = 8'h1F; mask_w = 8'hF1; watch_b = 1; glitch = 0; watch = 1;
    for (int k = 0; k < 6; k++) begin sel_ab = ~sel_ab; #1; end
    watch = 0; settle();
    check("R7 A to B matching bits steady", {7'd0, glitch}, 8'h00);
    check("R7 A to B final", b_out, 8'h1F);
    ext_b = 8'h70; sel_ba = 1'b1; settle();
    ref_w = 8'h70; mask_w = 8'hF8; watch_b = 0; glitch = 0; watch = 1;
    for (int k = 0; k < 5; k++) begin sel_ba = ~sel_ba; #1; end
    watch = 0; settle();
    check("R7 B to A matching bits steady", {7'd0, glitch}, 8'h00);
    check("R7 B to A final", a_out, 8'h70);
  endtask

  task automatic t_hold();
    @(negedge clk);
    sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b1; en_ba_n = 1'b0;
    ext_a = 8'h5A; ext_a_en = 1'b1; ext_b_en = 1'b0; settle();
    check("R9 B driven from A", bus_b, 8'h5A);
    ext_a_en = 1'b0; settle(); settle();
    check("R9 A holds after release", bus_a, 8'h5A);
    check("R9 B holds after release", bus_b, 8'h5A);
    ext_b = 8'hC3; ext_b_en = 1'b1; settle();
    check("R9 A driven from B", bus_a, 8'hC3);
    ext_b_en = 1'b0; settle(); settle();
    check("R9 A holds second word", bus_a, 8'hC3);
    check("R9 B holds second word", bus_b, 8'hC3);
  endtask

  initial begin
    settle();
    t_reset();
    t_store_disabled();
    t_select();
    t_oe();
    t_glitch();
    t_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule